// File: doc/BRIEF.md
# Serial Receiver with Flow-Controlled Receive Queue

This block turns an asynchronous serial line into bytes. A 16x oversample tick drives a frame sampler. The sampler checks each start bit at its middle and then samples every data, parity and stop bit at its middle. Good bytes enter a six-entry receive queue. The queue feeds a holding register that the consumer reads through a single-cycle read strobe. Every time a byte lands in the holding register, a one-cycle ready event is raised.

An active-low request-to-send output throttles the far-end transmitter. It is withdrawn once only four queue slots remain free. It is granted again only after the queue and the holding register are both fully drained.

A stop or suspend command withdraws request-to-send, but the line is still accepted for a grace window of five frame times. At the end of that window a one-cycle timeout event is issued and the line is ignored until the next start command.

Line problems are reported in a sticky error-flag vector and by a one-cycle error event. The problems are a missing stop bit, a held-low break, bad even parity, and a start bit that arrives while the storage is full.

Top module: `serial_rx_flow`

## Requirements
- R1: After synchronous reset: the error flags are 0, `hold_data_o` is 0, no event output is high, the receiver is stopped, and `rts_n_o` equals `flow_en_i`.
- R2: A frame is a low start bit, then DW data bits least-significant first, then an optional parity bit, then a high stop bit. Each bit is 16 oversample ticks long. Bytes reach `hold_data_o` in arrival order, and `rdy_evt_o` pulses for one cycle each time the holding register is loaded.
- R3: A read strobe while the holding register is full moves the next queued byte into it. A read strobe while storage is empty loads nothing, raises no ready event and leaves `hold_data_o` unchanged.
- R4: With `flow_en_i`=1 and the receiver running, `rts_n_o` goes high once the queue behind the holding register holds two bytes, which leaves four slots free.
- R5: Once high through R4, `rts_n_o` returns low only after the queue and the holding register are both empty.
- R6: With `flow_en_i`=0, `rts_n_o` is low at all times.
- R7: A stop or suspend pulse while running drives `rts_n_o` high. Frames whose start bits arrive during the following 5 frame times are still stored. At the end of that window `tmo_evt_o` pulses once, and later frames are ignored until a start pulse.
- R8: A low stop bit sets the framing flag (`err_flags_o[2]`) and discards the byte.
- R9: A line held low for 10 bit times, or 11 with parity enabled, sets the break flag (`err_flags_o[3]`). The framing flag of the same low period is always set earlier.
- R10: With `parity_en_i`=1, the parity bit must make the total count of ones in data plus parity even. A mismatch sets the parity flag (`err_flags_o[1]`), and the byte is still stored.
- R11: A start bit validated while the holding register and all six queue entries are full sets the overrun flag (`err_flags_o[0]`). If storage is still full when that byte completes, it replaces the newest queued byte.
- R12: Every flag-setting condition pulses `err_evt_o` for one cycle. Flags stay set until a start pulse clears them.
- R13: A low pulse on the line that has ended by the start bit's mid-point is discarded without a byte or a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_rx_i | input | 1 | Start-receive pulse; also clears the error flags |
| stop_rx_i | input | 1 | Stop-receive pulse |
| suspend_i | input | 1 | Suspend pulse, same receiver effect as stop |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | Oversample tick, 16 per bit time |
| rd_i | input | 1 | Read strobe for the holding register |
| parity_en_i | input | 1 | Enable the even-parity bit |
| flow_en_i | input | 1 | Enable request-to-send flow control |
| hold_data_o | output | DW | Holding-register byte |
| rdy_evt_o | output | 1 | Pulse when the holding register is loaded |
| rts_n_o | output | 1 | Request-to-send, active low |
| tmo_evt_o | output | 1 | Pulse at the end of the grace window |
| err_evt_o | output | 1 | Pulse on any new line error |
| err_flags_o | output | 4 | Sticky flags: [0] overrun, [1] parity, [2] framing, [3] break |

## Verification
A queue pointer or level that drifts shows up within one read as a wrong or repeated byte on `hold_data_o`. It also shows up as a request-to-send edge one byte early or late. A sampler whose bit counter is off by one corrupts the byte or raises the framing flag on the very frame where it goes wrong. A grace timer with a wrong limit moves the timeout pulse by a whole frame or more, which a window check around the expected time catches. The overrun replacement order appears only when the seven stored bytes are read back, so that sequence is read out in full.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Receiver sampler phases
    typedef enum logic [2:0] {
        SMP_IDLE,
        SMP_START,
        SMP_DATA,
        SMP_PAR,
        SMP_STOP,
        SMP_WAITHI
    } smp_state_e;

    // Run state of the receiver as a whole
    typedef enum logic [1:0] {
        RUN_OFF,
        RUN_ON,
        RUN_GRACE
    } run_state_e;

    // Sticky error flags, overrun in the least significant bit
    typedef struct packed {
        logic brk;
        logic framing;
        logic parity;
        logic overrun;
    } err_flags_t;

    // Bit times in one frame: start, data, optional parity, stop
    function automatic int unsigned frame_bits(input logic par_en, input int unsigned dw);
        return dw + 2 + (par_en ? 1 : 0);
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned OS   = 16,
    parameter int unsigned SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic          par_en_i,
    output logic          start_ok_o,
    output logic          byte_vld_o,
    output logic [DW-1:0] byte_o,
    output logic          par_bad_o,
    output logic          framing_o,
    output logic          break_o
);
    localparam int unsigned CW     = $clog2(OS);
    localparam int unsigned BW     = (DW > 1) ? $clog2(DW) : 1;
    localparam int unsigned LOWMAX = OS * (DW + 3);
    localparam int unsigned LW     = $clog2(LOWMAX + 1);
    localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    logic [SYNC-1:0] sync_q;
    logic            rx_s;
    smp_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [BW-1:0]   idx_q;
    logic [DW-1:0]   shreg_q;
    logic            par_q;
    logic [LW-1:0]   low_q;
    logic            brk_done_q;
    logic [LW-1:0]   brk_lim;

    // Line synchronizer, idle high
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC-2:0], rx_i};
    end
    assign rx_s = sync_q[SYNC-1];

    assign brk_lim = LW'(OS * frame_bits(par_en_i, DW));

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q    <= SMP_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            low_q      <= '0;
            brk_done_q <= 1'b0;
            start_ok_o <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            par_bad_o  <= 1'b0;
            framing_o  <= 1'b0;
            break_o    <= 1'b0;
        end else begin
            start_ok_o <= 1'b0;
            byte_vld_o <= 1'b0;
            par_bad_o  <= 1'b0;
            framing_o  <= 1'b0;
            break_o    <= 1'b0;
            if (tick_i) begin
                // Length of the current low run on the line
                if (rx_s) begin
                    low_q      <= '0;
                    brk_done_q <= 1'b0;
                end else begin
                    if (low_q != LW'(LOWMAX)) low_q <= low_q + LW'(1);
                    if (!brk_done_q && (low_q + LW'(1) == brk_lim)) begin
                        break_o    <= 1'b1;
                        brk_done_q <= 1'b1;
                    end
                end
                case (state_q)
                    SMP_IDLE: begin
                        if (!rx_s) begin
                            state_q <= SMP_START;
                            cnt_q   <= CW'(1);
                        end
                    end
                    SMP_START: begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            if (!rx_s) begin
                                state_q    <= SMP_DATA;
                                idx_q      <= '0;
                                start_ok_o <= 1'b1;
                            end else begin
                                state_q <= SMP_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    SMP_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shreg_q <= {rx_s, shreg_q[DW-1:1]};
                            if (idx_q == BW'(DW - 1))
                                state_q <= par_en_i ? SMP_PAR : SMP_STOP;
                            else
                                idx_q <= idx_q + BW'(1);
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    SMP_PAR: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            par_q   <= rx_s;
                            state_q <= SMP_STOP;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    SMP_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            if (rx_s) begin
                                byte_vld_o <= 1'b1;
                                byte_o     <= shreg_q;
                                par_bad_o  <= par_en_i && ((^shreg_q) != par_q);
                                state_q    <= SMP_IDLE;
                            end else begin
                                framing_o <= 1'b1;
                                state_q   <= SMP_WAITHI;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    SMP_WAITHI: begin
                        if (rx_s) state_q <= SMP_IDLE;
                    end
                    default: state_q <= SMP_IDLE;
                endcase
            end
        end
    end

    // R9: a break only ever follows the framing error of the same low run
    assert_break_after_framing_R9: assert property (@(posedge clk) disable iff (rst)
        break_o |-> state_q == SMP_WAITHI);

    // R8: a framing report and a delivered byte never coincide
    assert_framing_no_byte_R8: assert property (@(posedge clk) disable iff (rst)
        framing_o |-> !byte_vld_o);

endmodule

// File: rtl/srx_queue.sv
module srx_queue #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 6,
    parameter int unsigned LVW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push_i,
    input  logic [DW-1:0]  push_data_i,
    input  logic           rd_i,
    output logic [LVW-1:0] level_o,
    output logic           hold_vld_o,
    output logic [DW-1:0]  hold_o,
    output logic           load_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]  mem_q [DEPTH];
    logic [PW-1:0]  wr_q, rd_q;
    logic           full, pop, push_ok, overwrite;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    assign full      = (level_o == LVW'(DEPTH));
    assign pop       = (!hold_vld_o || rd_i) && (level_o != '0);
    assign push_ok   = push_i && (!full || pop);
    assign overwrite = push_i && full && !pop;

    always_ff @(posedge clk) begin
        if (push_ok)        mem_q[wr_q]          <= push_data_i;
        else if (overwrite) mem_q[ptr_dec(wr_q)] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q       <= '0;
            rd_q       <= '0;
            level_o    <= '0;
            hold_vld_o <= 1'b0;
            hold_o     <= '0;
            load_o     <= 1'b0;
        end else begin
            load_o <= pop;
            if (push_ok) wr_q <= ptr_inc(wr_q);
            level_o <= level_o + LVW'(push_ok) - LVW'(pop);
            if (pop) begin
                hold_o     <= mem_q[rd_q];
                hold_vld_o <= 1'b1;
                rd_q       <= ptr_inc(rd_q);
            end else if (rd_i) begin
                hold_vld_o <= 1'b0;
            end
        end
    end

    // R11: the level never exceeds the queue depth
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        level_o <= LVW'(DEPTH));

    // R11: replacing the newest entry keeps the queue full
    assert_overwrite_full_R11: assert property (@(posedge clk) disable iff (rst)
        overwrite |=> level_o == LVW'(DEPTH));

    // R3: a load always leaves valid data in the holding register
    assert_load_has_data_R3: assert property (@(posedge clk) disable iff (rst)
        load_o |-> hold_vld_o);

endmodule

// File: rtl/srx_flow.sv
module srx_flow
    import srx_pkg::*;
#(
    parameter int unsigned DW            = 8,
    parameter int unsigned OS            = 16,
    parameter int unsigned DEPTH         = 6,
    parameter int unsigned GRACE_FRAMES  = 5,
    parameter int unsigned THROTTLE_FREE = 4,
    parameter int unsigned LVW           = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           stop_i,
    input  logic           suspend_i,
    input  logic           flow_en_i,
    input  logic           par_en_i,
    input  logic           tick_i,
    input  logic [LVW-1:0] level_i,
    input  logic           hold_vld_i,
    output logic           rx_en_o,
    output logic           rts_n_o,
    output logic           tmo_evt_o
);
    localparam int unsigned TMAX   = GRACE_FRAMES * OS * (DW + 3);
    localparam int unsigned TW     = $clog2(TMAX + 1);
    localparam logic [LVW-1:0] THR = LVW'(DEPTH - THROTTLE_FREE);

    run_state_e     run_q, run_d;
    logic [TW-1:0]  tmr_q, tmr_d, grace_lim;
    logic           thr_q, thr_d, tmo_d;

    assign grace_lim = TW'(GRACE_FRAMES * OS * frame_bits(par_en_i, DW));

    always_comb begin
        run_d = run_q;
        tmr_d = tmr_q;
        tmo_d = 1'b0;
        if (start_i) begin
            run_d = RUN_ON;
            tmr_d = '0;
        end else if ((stop_i || suspend_i) && run_q == RUN_ON) begin
            run_d = RUN_GRACE;
            tmr_d = '0;
        end else if (run_q == RUN_GRACE && tick_i) begin
            if (tmr_q + TW'(1) >= grace_lim) begin
                run_d = RUN_OFF;
                tmo_d = 1'b1;
            end else begin
                tmr_d = tmr_q + TW'(1);
            end
        end
        // Throttle sets at the level mark and clears only when fully drained
        if (level_i >= THR)                      thr_d = 1'b1;
        else if (level_i == '0 && !hold_vld_i)   thr_d = 1'b0;
        else                                     thr_d = thr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= RUN_OFF;
            tmr_q     <= '0;
            thr_q     <= 1'b0;
            tmo_evt_o <= 1'b0;
            rts_n_o   <= flow_en_i;
        end else begin
            run_q     <= run_d;
            tmr_q     <= tmr_d;
            thr_q     <= thr_d;
            tmo_evt_o <= tmo_d;
            rts_n_o   <= flow_en_i && (run_d != RUN_ON || thr_d);
        end
    end

    assign rx_en_o = (run_q != RUN_OFF);

    // R6: without flow control the request-to-send pin stays granted
    assert_rts_granted_no_flow_R6: assert property (@(posedge clk) disable iff (rst)
        !flow_en_i |=> !rts_n_o);

    // R7: a timeout only ends a grace window
    assert_tmo_ends_grace_R7: assert property (@(posedge clk) disable iff (rst)
        tmo_evt_o |-> (run_q == RUN_OFF));

    // R7: the timeout is a single-cycle pulse
    assert_tmo_single_R7: assert property (@(posedge clk) disable iff (rst)
        tmo_evt_o |=> !tmo_evt_o);

    // R5: the throttle releases only once storage was empty
    assert_release_drained_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(thr_q) |-> $past(level_i == '0 && !hold_vld_i));

endmodule

// File: rtl/serial_rx_flow.sv
module serial_rx_flow
    import srx_pkg::*;
#(
    parameter int unsigned DW            = 8,
    parameter int unsigned OS            = 16,
    parameter int unsigned DEPTH         = 6,
    parameter int unsigned GRACE_FRAMES  = 5,
    parameter int unsigned THROTTLE_FREE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_rx_i,
    input  logic          stop_rx_i,
    input  logic          suspend_i,
    input  logic          rx_i,
    input  logic          os_tick_i,
    input  logic          rd_i,
    input  logic          parity_en_i,
    input  logic          flow_en_i,
    output logic [DW-1:0] hold_data_o,
    output logic          rdy_evt_o,
    output logic          rts_n_o,
    output logic          tmo_evt_o,
    output logic          err_evt_o,
    output logic [3:0]    err_flags_o
);
    localparam int unsigned LVW = $clog2(DEPTH + 1);

    logic           rx_en;
    logic           start_ok, byte_vld, par_bad, framing, brk;
    logic [DW-1:0]  rx_byte;
    logic [LVW-1:0] level;
    logic           hold_vld;
    logic           store_full;
    err_flags_t     set_v, flags_q;

    srx_sampler #(.DW(DW), .OS(OS), .SYNC(2)) i_sampler (
        .clk        (clk),
        .rst        (rst),
        .en_i       (rx_en),
        .rx_i       (rx_i),
        .tick_i     (os_tick_i),
        .par_en_i   (parity_en_i),
        .start_ok_o (start_ok),
        .byte_vld_o (byte_vld),
        .byte_o     (rx_byte),
        .par_bad_o  (par_bad),
        .framing_o  (framing),
        .break_o    (brk)
    );

    srx_queue #(.DW(DW), .DEPTH(DEPTH), .LVW(LVW)) i_queue (
        .clk         (clk),
        .rst         (rst),
        .push_i      (byte_vld),
        .push_data_i (rx_byte),
        .rd_i        (rd_i),
        .level_o     (level),
        .hold_vld_o  (hold_vld),
        .hold_o      (hold_data_o),
        .load_o      (rdy_evt_o)
    );

    srx_flow #(
        .DW(DW), .OS(OS), .DEPTH(DEPTH), .GRACE_FRAMES(GRACE_FRAMES),
        .THROTTLE_FREE(THROTTLE_FREE), .LVW(LVW)
    ) i_flow (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_rx_i),
        .stop_i     (stop_rx_i),
        .suspend_i  (suspend_i),
        .flow_en_i  (flow_en_i),
        .par_en_i   (parity_en_i),
        .tick_i     (os_tick_i),
        .level_i    (level),
        .hold_vld_i (hold_vld),
        .rx_en_o    (rx_en),
        .rts_n_o    (rts_n_o),
        .tmo_evt_o  (tmo_evt_o)
    );

    assign store_full = hold_vld && (level == LVW'(DEPTH));

    always_comb begin
        set_v.overrun = start_ok && store_full;
        set_v.parity  = byte_vld && par_bad;
        set_v.framing = framing;
        set_v.brk     = brk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            err_evt_o <= 1'b0;
        end else begin
            err_evt_o <= |set_v;
            if (start_rx_i) flags_q <= set_v;
            else            flags_q <= flags_q | set_v;
        end
    end

    assign err_flags_o = flags_q;

    // R11: overrun is only ever raised with storage full
    assert_overrun_when_full_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.overrun) |-> $past(store_full));

    // R12: every newly raised flag comes with an error event
    assert_flag_has_event_R12: assert property (@(posedge clk) disable iff (rst)
        (flags_q & ~$past(flags_q)) != '0 |-> err_evt_o);

endmodule

// File: tb/test_serial_rx_flow.sv
module test_serial_rx_flow;
    localparam int DW = 8;
    localparam int BITCLK = 32;       // 16 ticks x 2 clocks per tick
    localparam int GRACE_CLK = 5 * 10 * BITCLK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_rx = 0, stop_rx = 0, suspend = 0, rx = 1, tick = 0, rd = 0;
    logic parity_en = 0, flow_en = 1;
    logic [DW-1:0] hold_data;
    logic rdy_evt, rts_n, tmo_evt, err_evt;
    logic [3:0] err_flags;

    int n_tests = 0, n_fail = 0;
    int rdy_cnt = 0, tmo_cnt = 0, err_cnt = 0, cyc = 0;
    int fr_cyc = -1, brk_cyc = -1;
    logic [3:0] flags_prev = '0;
    bit done = 0;
    logic [DW-1:0] expq[$];

    always #2.5 clk = ~clk;

    serial_rx_flow i_serial_rx_flow (
        .clk(clk), .rst(rst), .start_rx_i(start_rx), .stop_rx_i(stop_rx),
        .suspend_i(suspend), .rx_i(rx), .os_tick_i(tick), .rd_i(rd),
        .parity_en_i(parity_en), .flow_en_i(flow_en), .hold_data_o(hold_data),
        .rdy_evt_o(rdy_evt), .rts_n_o(rts_n), .tmo_evt_o(tmo_evt),
        .err_evt_o(err_evt), .err_flags_o(err_flags)
    );

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rdy_evt) rdy_cnt++;
            if (tmo_evt) tmo_cnt++;
            if (err_evt) err_cnt++;
            if (err_flags[2] && !flags_prev[2]) fr_cyc = cyc;
            if (err_flags[3] && !flags_prev[3]) brk_cyc = cyc;
        end
        flags_prev = err_flags;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic even_bit(input logic [DW-1:0] d);
        return ^d;
    endfunction

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input bit bad_par, input bit stop_v);
        rx = 1'b0; clocks(BITCLK);
        for (int i = 0; i < DW; i++) begin rx = d[i]; clocks(BITCLK); end
        if (parity_en) begin rx = even_bit(d) ^ bad_par; clocks(BITCLK); end
        rx = stop_v; clocks(BITCLK);
        rx = 1'b1; clocks(4);
    endtask

    task automatic pulse_start(); @(negedge clk); start_rx = 1; @(negedge clk); start_rx = 0; clocks(2); endtask
    task automatic pulse_stop();  @(negedge clk); stop_rx = 1;  @(negedge clk); stop_rx = 0;  clocks(2); endtask
    task automatic pulse_susp();  @(negedge clk); suspend = 1;  @(negedge clk); suspend = 0;  clocks(2); endtask

    // Reads the holding register and checks it against the model front
    task automatic read_front(input string req);
        logic [DW-1:0] e;
        e = expq.pop_front();
        check(hold_data == e, req, hold_data, e);
        @(negedge clk); rd = 1; @(negedge clk); rd = 0; clocks(3);
    endtask

    initial begin
        int r0, e0, pe, bad;
        logic [DW-1:0] d, b8;
        logic [DW-1:0] hd;
        int t_stop;
        r0 = $urandom(32'h1A2B);
        clocks(5);
        rst = 0;
        clocks(2);
        // R1 reset state
        check(err_flags == 4'h0, "R1 flags", err_flags, 0);
        check(hold_data == 8'h00, "R1 hold", hold_data, 0);
        check(rts_n == 1'b1, "R1 rts idle", rts_n, 1);
        check(rdy_cnt == 0 && tmo_cnt == 0 && err_cnt == 0, "R1 events", rdy_cnt + tmo_cnt + err_cnt, 0);

        pulse_start();
        check(rts_n == 1'b0, "R7 rts granted when running", rts_n, 0);

        // R2 / R4 / R5 directed
        expq.push_back(8'hA5); send_frame(8'hA5, 0, 1);
        check(rdy_cnt == 1, "R2 ready pulse", rdy_cnt, 1);
        check(hold_data == 8'hA5, "R2 first byte", hold_data, 8'hA5);
        expq.push_back(8'h3C); send_frame(8'h3C, 0, 1);
        check(rts_n == 1'b0, "R4 rts low two stored", rts_n, 0);
        expq.push_back(8'h81); send_frame(8'h81, 0, 1);
        check(rts_n == 1'b1, "R4 rts high at mark", rts_n, 1);
        read_front("R2 order");
        check(rts_n == 1'b1, "R5 rts held after one read", rts_n, 1);
        read_front("R2 order");
        check(rts_n == 1'b1, "R5 rts held holding full", rts_n, 1);
        read_front("R2 order");
        check(rts_n == 1'b0, "R5 rts released drained", rts_n, 0);
        // R3 read while empty
        r0 = rdy_cnt; hd = hold_data;
        @(negedge clk); rd = 1; @(negedge clk); rd = 0; clocks(3);
        check(rdy_cnt == r0, "R3 empty read no event", rdy_cnt, r0);
        check(hold_data == hd, "R3 empty read keeps data", hold_data, hd);

        // R13 false start
        rx = 0; clocks(8); rx = 1; clocks(12 * BITCLK);
        check(rdy_cnt == r0, "R13 glitch no byte", rdy_cnt, r0);
        check(err_flags == 4'h0, "R13 glitch no flag", err_flags, 0);

        // R10 / R2 / R12 random
        for (int i = 0; i < 24; i++) begin
            pe = $urandom % 2; bad = (($urandom % 4) == 0) ? 1 : 0; d = DW'($urandom);
            parity_en = pe[0];
            pulse_start();
            r0 = rdy_cnt; e0 = err_cnt;
            expq.push_back(d);
            send_frame(d, bad[0], 1);
            check(rdy_cnt == r0 + 1, "R2 random ready", rdy_cnt, r0 + 1);
            check(err_flags[1] == (pe[0] & bad[0]), "R10 parity flag", err_flags[1], pe & bad);
            check(err_cnt == e0 + (pe & bad), "R12 parity event", err_cnt, e0 + (pe & bad));
            read_front("R2 random data");
        end
        parity_en = 0;
        pulse_start();

        // R11 overrun: seven stored, eighth replaces newest
        for (int i = 0; i < 7; i++) begin
            d = DW'(8'h10 + i); expq.push_back(d); send_frame(d, 0, 1);
        end
        check(err_flags[0] == 1'b0, "R11 no overrun at seven", err_flags[0], 0);
        b8 = 8'hEE; send_frame(b8, 0, 1);
        check(err_flags[0] == 1'b1, "R11 overrun flag", err_flags[0], 1);
        void'(expq.pop_back()); expq.push_back(b8);
        for (int i = 0; i < 7; i++) read_front("R11 readback");
        check(rts_n == 1'b0, "R5 rts released after overrun", rts_n, 0);

        // R8 framing
        pulse_start();
        r0 = rdy_cnt; e0 = err_cnt;
        send_frame(8'h55, 0, 0);
        check(err_flags[2] == 1'b1, "R8 framing flag", err_flags[2], 1);
        check(rdy_cnt == r0, "R8 byte discarded", rdy_cnt, r0);
        check(err_cnt == e0 + 1, "R12 framing event", err_cnt, e0 + 1);
        expq.push_back(8'h77); send_frame(8'h77, 0, 1);
        check(err_flags[2] == 1'b1, "R12 framing sticky", err_flags[2], 1);
        read_front("R2 after framing");
        pulse_start();
        check(err_flags == 4'h0, "R12 start clears flags", err_flags, 0);

        // R9 break with framing first
        fr_cyc = -1; brk_cyc = -1;
        rx = 0; clocks(12 * BITCLK); rx = 1; clocks(2 * BITCLK);
        check(err_flags[3] == 1'b1, "R9 break flag", err_flags[3], 1);
        check(fr_cyc > 0 && fr_cyc < brk_cyc, "R9 framing before break", fr_cyc, brk_cyc);
        pulse_start();

        // R7 stop with grace window
        pulse_stop();
        t_stop = cyc;
        check(rts_n == 1'b1, "R7 rts high after stop", rts_n, 1);
        r0 = rdy_cnt;
        expq.push_back(8'hC3); send_frame(8'hC3, 0, 1);
        check(rdy_cnt == r0 + 1, "R7 late byte accepted", rdy_cnt, r0 + 1);
        read_front("R7 late byte");
        while (cyc < t_stop + GRACE_CLK - 60) @(negedge clk);
        check(tmo_cnt == 0, "R7 no early timeout", tmo_cnt, 0);
        while (cyc < t_stop + GRACE_CLK + 60) @(negedge clk);
        check(tmo_cnt == 1, "R7 timeout once", tmo_cnt, 1);
        r0 = rdy_cnt;
        send_frame(8'h5A, 0, 1);
        check(rdy_cnt == r0, "R7 ignored after timeout", rdy_cnt, r0);

        // R7 suspend behaves as stop
        pulse_start();
        pulse_susp();
        t_stop = cyc;
        check(rts_n == 1'b1, "R7 rts high after suspend", rts_n, 1);
        while (cyc < t_stop + GRACE_CLK + 60) @(negedge clk);
        check(tmo_cnt == 2, "R7 suspend timeout", tmo_cnt, 2);

        // R6 flow control off
        flow_en = 0; clocks(3);
        check(rts_n == 1'b0, "R6 rts low while stopped", rts_n, 0);
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            d = DW'($urandom); expq.push_back(d); send_frame(d, 0, 1);
        end
        check(rts_n == 1'b0, "R6 rts low with three stored", rts_n, 0);
        for (int i = 0; i < 3; i++) read_front("R6 readback");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule